// File: doc/BRIEF.md
# Sequenced Three-Switch PWM Generator

This block drives the three power switches of a single-supply converter that produces a step-down output, a step-up output and an inverted output. It counts a fixed switching period from the logic clock; with the defaults that is 400 cycles, meaning a 20 µs period at 50 kHz switching from a 20 MHz clock. The inverting-branch switch and the step-down switch both turn on at the start of every period. The step-down switch hands over directly to the boost-charging switch. Once both of those are off, the rest of the period stays quiet until the end. The last 20 counts of every period form a dead interval in which all three gates are held low.

Three duty values arrive as unsigned clock counts. They are captured only at the period boundary, so a controller may update them at any time without disturbing the period that is running. A one-cycle sample strobe marks the first position of every period, so that an external converter can take one valley-current sample per period. A synchronous active-high reset silences every output, restarts the count and clears the captured duties. The first period after reset is therefore idle.

Top module: `tri_switch_pwm`

## Requirements
- R1: The period is PERIOD_CYC (400) clock cycles. Positions are numbered 0 to 399, starting at the strobe. `sample_o` is high for position 0 only, once per period.
- R2: `inv_gate_o` is high exactly at positions p where p < min(inv duty, 380).
- R3: `buck_gate_o` is high exactly at positions p where p < min(buck duty, 380).
- R4: `chg_gate_o` is high exactly at positions p where buck duty ≤ p < min(buck duty + charge duty, 380). It rises in the same cycle in which `buck_gate_o` falls.
- R5: `buck_gate_o` and `chg_gate_o` are never high in the same cycle.
- R6: In positions 380 to 399 all three gate outputs are low.
- R7: The duty inputs are sampled only on the clock edge that ends a period. Changes made during a period have no effect until the next period.
- R8: A duty value of 0 keeps its gate low for the whole period. This covers a buck duty of 0 for `buck_gate_o` and a charge duty of 0 for `chg_gate_o`.
- R9: While `rst` is high at a clock edge, all outputs go low after that edge. After release, position 0 follows on the first edge, and that first period uses zero duties.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Logic clock (20 MHz nominal) |
| rst | input | 1 | Synchronous active-high reset |
| inv_cnt_i | input | CW (9) | On-time of the inverting-branch switch, in clock counts |
| buck_cnt_i | input | CW (9) | On-time of the step-down switch, in clock counts |
| chg_cnt_i | input | CW (9) | On-time of the boost-charging switch after hand-over, in clock counts |
| inv_gate_o | output | 1 | Gate drive, inverting-branch switch |
| buck_gate_o | output | 1 | Gate drive, step-down switch |
| chg_gate_o | output | 1 | Gate drive, boost-charging switch |
| sample_o | output | 1 | One-cycle strobe at position 0 of each period |

## Verification
The bench walks through duty sets that reach the 380-count limit and go past it. Some of these sets overflow the buck-plus-charge sum, and some have zero buck or zero charge time. A design that skipped clipping would drive a gate into the dead interval, and a design with an off-by-one window would change the high-cycle counts. Halfway through every period the bench writes garbage to the duty inputs, so a design without shadow capture would corrupt the second half of the period. A reset applied in the middle of a period checks that the buck gate drops at once and that the period restarts idle from position 0.

// File: rtl/tsw_pkg.sv
package tsw_pkg;
  localparam int unsigned NUM_CH  = 3;
  localparam int unsigned CH_INV  = 0;
  localparam int unsigned CH_BUCK = 1;
  localparam int unsigned CH_CHG  = 2;

  // Clip a window end to the last active position plus one.
  function automatic int unsigned clamp_hi(int unsigned v, int unsigned lim);
    return (v > lim) ? lim : v;
  endfunction

  // Half-open window membership: lo <= p < hi.
  function automatic logic in_span(int unsigned p, int unsigned lo, int unsigned hi);
    return (p >= lo) && (p < hi);
  endfunction
endpackage

// File: rtl/tsw_period_timer.sv
module tsw_period_timer #(
  parameter int unsigned PERIOD_CYC = 400,
  parameter int unsigned CW         = 9
) (
  input  logic          clk,
  input  logic          rst,
  output logic [CW-1:0] pos_o,
  output logic          wrap_o
);
  localparam logic [CW-1:0] LAST_POS = CW'(PERIOD_CYC - 1);

  logic [CW-1:0] cnt_q;

  assign wrap_o = (cnt_q == LAST_POS);
  assign pos_o  = cnt_q;

  always_ff @(posedge clk) begin
    if (rst)         cnt_q <= '0;
    else if (wrap_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + CW'(1);
  end

  // R1: the count restarts after the last position
  p_wrap_zero_r1: assert property (@(posedge clk) disable iff (rst)
    wrap_o |=> (cnt_q == '0));
  // R1: otherwise it advances by exactly one
  p_count_step_r1: assert property (@(posedge clk) disable iff (rst)
    !wrap_o |=> (cnt_q == $past(cnt_q) + CW'(1)));
  // R1: the position never leaves the period
  p_cnt_range_r1: assert property (@(posedge clk) disable iff (rst)
    32'(cnt_q) < PERIOD_CYC);
endmodule

// File: rtl/tsw_duty_shadow.sv
module tsw_duty_shadow #(
  parameter int unsigned CW     = 9,
  parameter int unsigned NUM_CH = 3
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      load_i,
  input  logic [NUM_CH-1:0][CW-1:0] req_i,
  output logic [NUM_CH-1:0][CW-1:0] act_o
);
  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic [CW-1:0] hold_q;
    always_ff @(posedge clk) begin
      if (rst)         hold_q <= '0;
      else if (load_i) hold_q <= req_i[c];
    end
    assign act_o[c] = hold_q;
  end

  // R7: the captured duties only move at a period boundary
  p_hold_mid_period_r7: assert property (@(posedge clk) disable iff (rst)
    !load_i |=> $stable(act_o));
endmodule

// File: rtl/tsw_gate_seq.sv
module tsw_gate_seq
  import tsw_pkg::*;
#(
  parameter int unsigned PERIOD_CYC = 400,
  parameter int unsigned ACTIVE_LIM = 380,
  parameter int unsigned CW         = 9
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [CW-1:0]             pos_i,
  input  logic [NUM_CH-1:0][CW-1:0] duty_i,
  output logic                      inv_o,
  output logic                      buck_o,
  output logic                      chg_o,
  output logic                      strobe_o
);
  int unsigned pos_w;
  int unsigned inv_end;
  int unsigned buck_end;
  int unsigned chg_begin;
  int unsigned chg_end;
  logic        inv_win;
  logic        buck_win;
  logic        chg_win;
  logic        start_win;
  logic [CW-1:0] pos_q;

  assign pos_w     = 32'(pos_i);
  assign inv_end   = clamp_hi(32'(duty_i[CH_INV]), ACTIVE_LIM);
  assign buck_end  = clamp_hi(32'(duty_i[CH_BUCK]), ACTIVE_LIM);
  assign chg_begin = 32'(duty_i[CH_BUCK]);
  assign chg_end   = clamp_hi(32'(duty_i[CH_BUCK]) + 32'(duty_i[CH_CHG]), ACTIVE_LIM);

  assign inv_win   = in_span(pos_w, 0, inv_end);
  assign buck_win  = in_span(pos_w, 0, buck_end);
  assign chg_win   = in_span(pos_w, chg_begin, chg_end);
  assign start_win = (pos_w == 0);

  always_ff @(posedge clk) begin
    if (rst) begin
      inv_o    <= 1'b0;
      buck_o   <= 1'b0;
      chg_o    <= 1'b0;
      strobe_o <= 1'b0;
      pos_q    <= '0;
    end else begin
      inv_o    <= inv_win;
      buck_o   <= buck_win;
      chg_o    <= chg_win;
      strobe_o <= start_win;
      pos_q    <= pos_i;
    end
  end

  // R5: buck and charge switches never overlap
  p_no_overlap_r5: assert property (@(posedge clk) disable iff (rst)
    !(buck_o && chg_o));
  // R6: dead interval is quiet
  p_dead_quiet_r6: assert property (@(posedge clk) disable iff (rst)
    (32'(pos_q) >= ACTIVE_LIM) |-> !(inv_o || buck_o || chg_o));
  // R4: charge switch takes over in the cycle the buck switch releases
  p_handoff_r4: assert property (@(posedge clk) disable iff (rst)
    (buck_o && !buck_win && (chg_end > chg_begin)) |=> chg_o);
  // R8: zero duties keep their gates low
  p_zero_buck_r8: assert property (@(posedge clk) disable iff (rst)
    (duty_i[CH_BUCK] == '0) |-> !buck_o);
  p_zero_chg_r8: assert property (@(posedge clk) disable iff (rst)
    (duty_i[CH_CHG] == '0) |-> !chg_o);
  // R1: the strobe is a single cycle
  p_strobe_single_r1: assert property (@(posedge clk) disable iff (rst)
    strobe_o |=> !strobe_o);
  // R9: reset silences every output
  p_reset_quiet_r9: assert property (@(posedge clk)
    rst |=> !(inv_o || buck_o || chg_o || strobe_o));
endmodule

// File: rtl/tri_switch_pwm.sv
module tri_switch_pwm
  import tsw_pkg::*;
#(
  parameter  int unsigned PERIOD_CYC = 400,
  parameter  int unsigned DEAD_CYC   = 20,
  localparam int unsigned CW         = $clog2(PERIOD_CYC)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] inv_cnt_i,
  input  logic [CW-1:0] buck_cnt_i,
  input  logic [CW-1:0] chg_cnt_i,
  output logic          inv_gate_o,
  output logic          buck_gate_o,
  output logic          chg_gate_o,
  output logic          sample_o
);
  localparam int unsigned ACTIVE_LIM = PERIOD_CYC - DEAD_CYC;

  logic [CW-1:0]             pos;
  logic                      period_end;
  logic [NUM_CH-1:0][CW-1:0] duty_req;
  logic [NUM_CH-1:0][CW-1:0] duty_act;

  assign duty_req[CH_INV]  = inv_cnt_i;
  assign duty_req[CH_BUCK] = buck_cnt_i;
  assign duty_req[CH_CHG]  = chg_cnt_i;

  tsw_period_timer #(.PERIOD_CYC(PERIOD_CYC), .CW(CW)) u_timer (
    .clk   (clk),
    .rst   (rst),
    .pos_o (pos),
    .wrap_o(period_end)
  );

  tsw_duty_shadow #(.CW(CW), .NUM_CH(NUM_CH)) u_shadow (
    .clk   (clk),
    .rst   (rst),
    .load_i(period_end),
    .req_i (duty_req),
    .act_o (duty_act)
  );

  tsw_gate_seq #(.PERIOD_CYC(PERIOD_CYC), .ACTIVE_LIM(ACTIVE_LIM), .CW(CW)) u_gates (
    .clk     (clk),
    .rst     (rst),
    .pos_i   (pos),
    .duty_i  (duty_act),
    .inv_o   (inv_gate_o),
    .buck_o  (buck_gate_o),
    .chg_o   (chg_gate_o),
    .strobe_o(sample_o)
  );
endmodule

// File: tb/tb_tri_switch_pwm.sv
module tb_tri_switch_pwm;
  localparam int CLK_PERIOD = 50;
  localparam int PER = 400;
  localparam int LIM = 380;
  localparam int NV  = 9;
  localparam int unsigned VEC [NV][3] = '{
    '{100, 150,  80},
    '{  0,   0,   0},
    '{380, 200, 180},
    '{399, 300, 150},
    '{ 50,   0, 120},
    '{250, 120,   0},
    '{390, 390,  50},
    '{  1,   1,   1},
    '{511, 511, 511}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [8:0] d_inv = '0, d_buck = '0, d_chg = '0;
  logic inv_g, buck_g, chg_g, smp;
  int checks = 0;
  int failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tri_switch_pwm dut (
    .clk(clk), .rst(rst),
    .inv_cnt_i(d_inv), .buck_cnt_i(d_buck), .chg_cnt_i(d_chg),
    .inv_gate_o(inv_g), .buck_gate_o(buck_g), .chg_gate_o(chg_g),
    .sample_o(smp)
  );

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk({inv_g, buck_g, chg_g, smp} == 4'b0, "R9 outputs low in reset",
        int'({inv_g, buck_g, chg_g, smp}), 0);
    rst = 1'b0;
  endtask

  // Checks one full period; drives garbage mid-period and the next duties before the boundary.
  task automatic run_period(input int a0, input int a1, input int a2,
                            input int n0, input int n1, input int n2);
    int m_inv = 0, m_buck = 0, m_chg = 0, m_smp = 0, m_late = 0;
    int n_inv = 0, n_buck = 0, n_chg = 0, ovl = 0, dead = 0;
    int x_inv, x_buck, x_chg;
    for (int p = 0; p < PER; p++) begin
      bit e_inv, e_buck, e_chg, e_smp;
      @(negedge clk);
      e_inv  = (p < ((a0 < LIM) ? a0 : LIM));
      e_buck = (p < a1) && (p < LIM);
      e_chg  = (p >= a1) && (p < a1 + a2) && (p < LIM);
      e_smp  = (p == 0);
      if (inv_g  !== e_inv)  m_inv++;
      if (buck_g !== e_buck) m_buck++;
      if (chg_g  !== e_chg)  m_chg++;
      if (smp    !== e_smp)  m_smp++;
      if (p > 200 && {inv_g, buck_g, chg_g} !== {e_inv, e_buck, e_chg}) m_late++;
      if (inv_g)  n_inv++;
      if (buck_g) n_buck++;
      if (chg_g)  n_chg++;
      if (buck_g && chg_g) ovl++;
      if (p >= LIM && (inv_g || buck_g || chg_g)) dead++;
      if (p == 200) begin
        d_inv  = 9'(a0 ^ 32'h1A5);
        d_buck = 9'(a1 ^ 32'h0F3);
        d_chg  = 9'(a2 ^ 32'h16C);
      end
      if (p == PER - 2) begin
        d_inv = 9'(n0); d_buck = 9'(n1); d_chg = 9'(n2);
      end
    end
    x_inv  = (a0 < LIM) ? a0 : LIM;
    x_buck = (a1 < LIM) ? a1 : LIM;
    x_chg  = (a1 >= LIM) ? 0 : (((a1 + a2 < LIM) ? a1 + a2 : LIM) - a1);
    chk(m_smp == 0,  "R1 strobe only at position 0", m_smp, 0);
    chk(m_inv == 0,  "R2 inverting window mismatches", m_inv, 0);
    chk(n_inv == x_inv, "R2 inverting on-cycles", n_inv, x_inv);
    chk(m_buck == 0, "R3 buck window mismatches", m_buck, 0);
    chk(n_buck == x_buck, "R3 buck on-cycles", n_buck, x_buck);
    chk(m_chg == 0,  "R4 charge window mismatches", m_chg, 0);
    chk(n_chg == x_chg, "R4 charge on-cycles", n_chg, x_chg);
    chk(ovl == 0,    "R5 buck/charge overlap cycles", ovl, 0);
    chk(dead == 0,   "R6 gates high in dead interval", dead, 0);
    chk(m_late == 0, "R7 mismatches after mid-period input change", m_late, 0);
    if (a1 == 0) chk(n_buck == 0, "R8 buck with zero duty", n_buck, 0);
    if (a2 == 0) chk(n_chg == 0,  "R8 charge with zero duty", n_chg, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    do_reset();
    // R9: first period after reset is idle
    run_period(0, 0, 0, int'(VEC[0][0]), int'(VEC[0][1]), int'(VEC[0][2]));
    for (int i = 0; i < NV; i++) begin
      if (i + 1 < NV)
        run_period(int'(VEC[i][0]), int'(VEC[i][1]), int'(VEC[i][2]),
                   int'(VEC[i+1][0]), int'(VEC[i+1][1]), int'(VEC[i+1][2]));
      else
        run_period(int'(VEC[i][0]), int'(VEC[i][1]), int'(VEC[i][2]), 100, 150, 80);
    end
    // R9: reset in mid-period while the buck gate is high
    repeat (120) @(negedge clk);
    chk(buck_g === 1'b1, "R9 precondition buck high before reset", int'(buck_g), 1);
    rst = 1'b1;
    @(negedge clk);
    chk({inv_g, buck_g, chg_g, smp} == 4'b0, "R9 outputs low after mid-period reset",
        int'({inv_g, buck_g, chg_g, smp}), 0);
    d_inv = 9'd100; d_buck = 9'd150; d_chg = 9'd80;
    do_reset();
    // R9: restart is idle and aligned even though the inputs held non-zero duties
    run_period(0, 0, 0, 60, 70, 90);
    run_period(60, 70, 90, 0, 0, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule